// File: doc/BRIEF.md
# Load-Compute-Store Adjacent-Sum Kernel

This kernel copies a fixed-length array of 32-bit signed integers from one memory region to another. On the way it replaces every element with the sum of itself and its predecessor. Three stages run at the same time and are joined by small FIFOs. A fetch stage issues one sequential read burst over wide memory beats and splits each beat into single elements. An adder stage turns one element into one result every cycle whenever its FIFOs permit. A writer stage gathers results back into wide beats and sends them out as one sequential write burst.

Software places the source and destination base addresses on the address inputs and pulses the start input. The kernel then issues exactly one read request and one write request. It pulses the done output once the final write beat has been accepted. By default a memory beat is 256 bits and carries 8 elements. Setting the memory width parameter equal to the element width gives one element per beat.

Top module: `lcs_kernel`

## Requirements
- R1: After reset, done_o, rd_req_valid_o, wr_req_valid_o, wr_valid_o and rd_ready_o are all low.
- R2: A start accepted while idle raises rd_req_valid_o on the next cycle with rd_req_addr_o equal to src_addr_i and rd_req_beats_o equal to 125. The request stays valid and stable until rd_req_ready_i accepts it, and it is issued exactly once per run.
- R3: Each run issues exactly one write request with wr_req_addr_o equal to dst_addr_i and wr_req_beats_o equal to 125. The request is held stable until accepted.
- R4: Within a 256-bit beat, lane k occupies bits [32k+31:32k] and holds array element 8b+k, where b is the beat number. This applies to both reads and writes.
- R5: Output element n equals input element n plus input element n-1, wrapping modulo 2^32. This holds for any pattern of valid/ready stalls on either memory channel.
- R6: The predecessor of element 0 is taken as zero in every run. Output element 0 equals input element 0 even after a previous run.
- R7: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and wr_data_o stays stable.
- R8: Exactly 125 write beats are sent per run. done_o is high for exactly one cycle: the cycle after the last write beat is accepted.
- R9: A start pulse during a run is ignored. It causes no new request and no change of addresses.
- R10: With both memory channels never stalling, done_o rises no more than 1024 cycles after the start pulse. This bound corresponds to one element per cycle plus fixed pipeline latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| src_addr_i | input | 32 | Byte base address of the source array |
| dst_addr_i | input | 32 | Byte base address of the destination array |
| done_o | output | 1 | One-cycle pulse after the last write beat |
| rd_req_valid_o | output | 1 | Read burst request valid |
| rd_req_ready_i | input | 1 | Read burst request accepted |
| rd_req_addr_o | output | 32 | Read burst start address |
| rd_req_beats_o | output | 16 | Read burst length in beats |
| rd_valid_i | input | 1 | Read data beat valid |
| rd_ready_o | output | 1 | Read data beat ready |
| rd_data_i | input | 256 | Read data beat |
| wr_req_valid_o | output | 1 | Write burst request valid |
| wr_req_ready_i | input | 1 | Write burst request accepted |
| wr_req_addr_o | output | 32 | Write burst start address |
| wr_req_beats_o | output | 16 | Write burst length in beats |
| wr_valid_o | output | 1 | Write data beat valid |
| wr_ready_i | input | 1 | Write data beat accepted |
| wr_data_o | output | 256 | Write data beat |

## Verification
Request signals are due the cycle after the start edge. The bench memory model samples every handshake one time unit after the falling edge, which is when the values that the next rising edge will capture are stable. The done pulse is due exactly one cycle after the last accepted write beat. The bench records the cycle numbers of both events and compares them. Element values are only final once the whole burst has been written, so they are compared after done_o plus a few idle cycles against sums computed from the bench's own source array. The no-stall run also checks the total cycle count from start to done against the R10 bound.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} xfer_st_e;

  function automatic int beats_for(int n_elem, int lanes);
    return (n_elem + lanes - 1) / lanes;
  endfunction
endpackage

// File: rtl/lcs_fifo.sv
module lcs_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) begin
        wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      end
      if (pop_i) begin
        rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      end
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o));
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty_o));
endmodule

// File: rtl/lcs_load.sv
module lcs_load
  import lcs_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int MEM_W  = 256,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int N_ELEM = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  output logic [LEN_W-1:0]  rd_req_beats_o,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [MEM_W-1:0]  rd_data_i,
  output logic              push_o,
  output logic [ELEM_W-1:0] elem_o,
  input  logic              full_i
);
  localparam int LANES   = MEM_W / ELEM_W;
  localparam int N_BEATS = beats_for(N_ELEM, LANES);
  localparam int LW      = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BW      = $clog2(N_BEATS + 1);
  localparam int EW      = $clog2(N_ELEM + 1);

  xfer_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BW-1:0]     beats_q;
  logic [EW-1:0]     ecnt_q;
  logic [LW-1:0]     lane_q;
  logic              have_q;
  logic [MEM_W-1:0]  beat_q;
  logic              push, beat_end, rd_fire;

  assign push     = have_q && !full_i;
  assign beat_end = (lane_q == LW'(LANES-1)) || (ecnt_q == EW'(N_ELEM-1));
  // take the next beat in the same cycle the last lane leaves
  assign rd_ready_o = (st_q == ST_XFER) && (beats_q != BW'(N_BEATS)) &&
                      (!have_q || (push && beat_end));
  assign rd_fire  = rd_valid_i && rd_ready_o;

  assign rd_req_valid_o = (st_q == ST_REQ);
  assign rd_req_addr_o  = addr_q;
  assign rd_req_beats_o = LEN_W'(N_BEATS);
  assign push_o         = push;
  assign elem_o         = beat_q[lane_q*ELEM_W +: ELEM_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      beats_q <= '0;
      ecnt_q  <= '0;
      lane_q  <= '0;
      have_q  <= 1'b0;
      beat_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_REQ;
          addr_q  <= base_i;
          beats_q <= '0;
          ecnt_q  <= '0;
          lane_q  <= '0;
          have_q  <= 1'b0;
        end
        ST_REQ: if (rd_req_ready_i) st_q <= ST_XFER;
        ST_XFER: begin
          if (rd_fire) begin
            beat_q  <= rd_data_i;
            beats_q <= beats_q + 1'b1;
            have_q  <= 1'b1;
          end else if (push && beat_end) begin
            have_q  <= 1'b0;
          end
          if (push) begin
            ecnt_q <= ecnt_q + 1'b1;
            lane_q <= beat_end ? '0 : lane_q + 1'b1;
            if (ecnt_q == EW'(N_ELEM-1)) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));
endmodule

// File: rtl/lcs_compute.sv
module lcs_compute #(
  parameter int ELEM_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_avail_i,
  input  logic [ELEM_W-1:0] in_data_i,
  output logic              in_pop_o,
  output logic              out_push_o,
  output logic [ELEM_W-1:0] out_data_o,
  input  logic              out_full_i
);
  logic [ELEM_W-1:0] prev_q;

  assign in_pop_o   = in_avail_i && !out_full_i;
  assign out_push_o = in_pop_o;
  assign out_data_o = in_data_i + prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= '0;
    else if (start_i)  prev_q <= '0;
    else if (in_pop_o) prev_q <= in_data_i;
  end
endmodule

// File: rtl/lcs_store.sv
module lcs_store
  import lcs_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int MEM_W  = 256,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int N_ELEM = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              elem_avail_i,
  input  logic [ELEM_W-1:0] elem_i,
  output logic              pop_o,
  output logic              wr_req_valid_o,
  input  logic              wr_req_ready_i,
  output logic [ADDR_W-1:0] wr_req_addr_o,
  output logic [LEN_W-1:0]  wr_req_beats_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [MEM_W-1:0]  wr_data_o,
  output logic              done_o
);
  localparam int LANES   = MEM_W / ELEM_W;
  localparam int N_BEATS = beats_for(N_ELEM, LANES);
  localparam int LW      = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BW      = $clog2(N_BEATS + 1);
  localparam int EW      = $clog2(N_ELEM + 1);

  logic              run_q, aw_pend_q, full_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MEM_W-1:0]  buf_q;
  logic [LW-1:0]     lane_q;
  logic [EW-1:0]     ecnt_q;
  logic [BW-1:0]     beats_q;
  logic              wr_fire, pop, beat_end, last_fire;

  assign wr_valid_o = full_q && !aw_pend_q;
  assign wr_fire    = wr_valid_o && wr_ready_i;
  assign beat_end   = (lane_q == LW'(LANES-1)) || (ecnt_q == EW'(N_ELEM-1));
  assign pop        = run_q && elem_avail_i && (ecnt_q != EW'(N_ELEM)) &&
                      (!full_q || wr_fire);
  assign last_fire  = wr_fire && (beats_q == BW'(N_BEATS-1));

  assign pop_o          = pop;
  assign wr_req_valid_o = aw_pend_q;
  assign wr_req_addr_o  = addr_q;
  assign wr_req_beats_o = LEN_W'(N_BEATS);
  assign wr_data_o      = buf_q;
  assign done_o         = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      aw_pend_q <= 1'b0;
      full_q    <= 1'b0;
      done_q    <= 1'b0;
      addr_q    <= '0;
      buf_q     <= '0;
      lane_q    <= '0;
      ecnt_q    <= '0;
      beats_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q     <= 1'b1;
        aw_pend_q <= 1'b1;
        addr_q    <= base_i;
        full_q    <= 1'b0;
        lane_q    <= '0;
        ecnt_q    <= '0;
        beats_q   <= '0;
      end else if (run_q) begin
        if (aw_pend_q && wr_req_ready_i) aw_pend_q <= 1'b0;
        if (wr_fire) begin
          full_q  <= 1'b0;
          beats_q <= beats_q + 1'b1;
        end
        if (pop) begin
          if (lane_q == '0) buf_q <= MEM_W'(elem_i);
          else              buf_q[lane_q*ELEM_W +: ELEM_W] <= elem_i;
          ecnt_q <= ecnt_q + 1'b1;
          lane_q <= beat_end ? '0 : lane_q + 1'b1;
          if (beat_end) full_q <= 1'b1;
        end
        if (last_fire) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_valid_o && !wr_req_ready_i |=> wr_req_valid_o && $stable(wr_req_addr_o));
  a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_data_o));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/lcs_kernel.sv
module lcs_kernel #(
  parameter int ELEM_W     = 32,
  parameter int MEM_W      = 256,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int N_ELEM     = 1000,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  output logic              done_o,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  output logic [LEN_W-1:0]  rd_req_beats_o,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [MEM_W-1:0]  rd_data_i,
  output logic              wr_req_valid_o,
  input  logic              wr_req_ready_i,
  output logic [ADDR_W-1:0] wr_req_addr_o,
  output logic [LEN_W-1:0]  wr_req_beats_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [MEM_W-1:0]  wr_data_o
);
  logic run_q, go;
  logic ld_push, in_full, in_empty, cp_pop, cp_push, out_full, out_empty, st_pop;
  logic [ELEM_W-1:0] ld_elem, in_head, cp_sum, out_head;

  assign go = start_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b0;
    else if (go)     run_q <= 1'b1;
    else if (done_o) run_q <= 1'b0;
  end

  lcs_load #(.ELEM_W(ELEM_W), .MEM_W(MEM_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
             .N_ELEM(N_ELEM)) i_load (
    .clk_i, .rst_ni, .start_i(go), .base_i(src_addr_i),
    .rd_req_valid_o, .rd_req_ready_i, .rd_req_addr_o, .rd_req_beats_o,
    .rd_valid_i, .rd_ready_o, .rd_data_i,
    .push_o(ld_push), .elem_o(ld_elem), .full_i(in_full)
  );

  lcs_fifo #(.W(ELEM_W), .DEPTH(FIFO_DEPTH)) i_in_fifo (
    .clk_i, .rst_ni, .push_i(ld_push), .wdata_i(ld_elem), .pop_i(cp_pop),
    .rdata_o(in_head), .full_o(in_full), .empty_o(in_empty)
  );

  lcs_compute #(.ELEM_W(ELEM_W)) i_compute (
    .clk_i, .rst_ni, .start_i(go), .in_avail_i(!in_empty), .in_data_i(in_head),
    .in_pop_o(cp_pop), .out_push_o(cp_push), .out_data_o(cp_sum),
    .out_full_i(out_full)
  );

  lcs_fifo #(.W(ELEM_W), .DEPTH(FIFO_DEPTH)) i_out_fifo (
    .clk_i, .rst_ni, .push_i(cp_push), .wdata_i(cp_sum), .pop_i(st_pop),
    .rdata_o(out_head), .full_o(out_full), .empty_o(out_empty)
  );

  lcs_store #(.ELEM_W(ELEM_W), .MEM_W(MEM_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
              .N_ELEM(N_ELEM)) i_store (
    .clk_i, .rst_ni, .start_i(go), .base_i(dst_addr_i),
    .elem_avail_i(!out_empty), .elem_i(out_head), .pop_o(st_pop),
    .wr_req_valid_o, .wr_req_ready_i, .wr_req_addr_o, .wr_req_beats_o,
    .wr_valid_o, .wr_ready_i, .wr_data_o, .done_o
  );
endmodule

// File: tb/test_lcs_kernel.sv
`timescale 1ns/1ps
module test_lcs_kernel;
  localparam int N  = 1000;
  localparam int L  = 8;
  localparam int NB = 125;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [31:0] src_addr_i = '0, dst_addr_i = '0;
  logic done_o, rd_req_valid_o, rd_ready_o, wr_req_valid_o, wr_valid_o;
  logic rd_req_ready_i = 1'b0, rd_valid_i = 1'b0, wr_req_ready_i = 1'b0, wr_ready_i = 1'b0;
  logic [31:0] rd_req_addr_o, wr_req_addr_o;
  logic [15:0] rd_req_beats_o, wr_req_beats_o;
  logic [255:0] rd_data_i = '0, wr_data_o;

  always #2.5 clk = ~clk;

  lcs_kernel i_lcs_kernel (
    .clk_i(clk), .rst_ni, .start_i, .src_addr_i, .dst_addr_i, .done_o,
    .rd_req_valid_o, .rd_req_ready_i, .rd_req_addr_o, .rd_req_beats_o,
    .rd_valid_i, .rd_ready_o, .rd_data_i,
    .wr_req_valid_o, .wr_req_ready_i, .wr_req_addr_o, .wr_req_beats_o,
    .wr_valid_o, .wr_ready_i, .wr_data_o
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] src [N];
  logic [31:0] got [N];
  int cyc = 0, rb = 0, wb = 0, rd_reqs = 0, wr_reqs = 0, done_cnt = 0;
  int done_cyc = 0, lw_cyc = 0, done_wb = 0;
  logic rd_on = 1'b0, stall_en = 1'b0;
  logic [31:0] rq_addr, wq_addr;
  logic [15:0] rq_beats, wq_beats;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] pack_beat(int b);
    logic [255:0] v = '0;
    for (int k = 0; k < L; k++) v[k*32 +: 32] = src[b*L + k];
    return v;
  endfunction

  function automatic logic [31:0] exp_sum(int n);
    return src[n] + ((n > 0) ? src[n-1] : 32'd0);
  endfunction

  // memory model: drive after falling edge, sample handshakes 1 ns later
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rd_req_ready_i = !stall_en || ($urandom % 2 == 0);
      wr_req_ready_i = !stall_en || ($urandom % 3 == 0);
      wr_ready_i     = !stall_en || ($urandom % 3 != 0);
      rd_valid_i     = rd_on && (rb < NB) && (!stall_en || ($urandom % 4 != 0));
      rd_data_i      = (rb < NB) ? pack_beat(rb) : '0;
      #1;
      if (rd_req_valid_o && rd_req_ready_i) begin
        rd_reqs++; rd_on = 1'b1; rb = 0;
        rq_addr = rd_req_addr_o; rq_beats = rd_req_beats_o;
      end
      if (rd_valid_i && rd_ready_o) rb++;
      if (wr_req_valid_o && wr_req_ready_i) begin
        wr_reqs++; wq_addr = wr_req_addr_o; wq_beats = wr_req_beats_o;
      end
      if (wr_valid_o && wr_ready_i) begin
        if (wb < NB) for (int k = 0; k < L; k++) got[wb*L + k] = wr_data_o[k*32 +: 32];
        wb++;
        lw_cyc = cyc;
      end
      if (done_o) begin
        done_cnt++; done_cyc = cyc; done_wb = wb;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic do_run(logic stall, logic [31:0] sa, logic [31:0] da, logic busy_start);
    int start_cyc;
    stall_en = stall;
    @(negedge clk);
    wb = 0; done_cnt = 0; rd_reqs = 0; wr_reqs = 0;
    src_addr_i = sa; dst_addr_i = da; start_i = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
    if (busy_start) begin
      repeat (60) @(negedge clk);
      src_addr_i = 32'hDEAD_0000; dst_addr_i = 32'hBEEF_0000; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #2;
    check("R2 read request count", 64'(rd_reqs), 64'd1);
    check("R2 read address", 64'(rq_addr), 64'(sa));
    check("R2 read beats", 64'(rq_beats), 64'(NB));
    check("R3 write request count", 64'(wr_reqs), 64'd1);
    check("R3 write address", 64'(wq_addr), 64'(da));
    check("R3 write beats", 64'(wq_beats), 64'(NB));
    check("R8 write beat count", 64'(wb), 64'(NB));
    check("R8 single done pulse", 64'(done_cnt), 64'd1);
    check("R8 done after last beat", 64'(done_cyc), 64'(lw_cyc + 1));
    check("R8 all beats before done", 64'(done_wb), 64'(NB));
    if (busy_start) check("R9 busy start ignored", 64'(rq_addr), 64'(sa));
    check("R6 first element uses zero predecessor", 64'(got[0]), 64'(src[0]));
    for (int n = 1; n < N; n++) check("R4/R5 element sum", 64'(got[n]), 64'(exp_sum(n)));
    if (!stall) check("R10 cycles start to done within bound",
                      64'(done_cyc - start_cyc <= N + 24), 64'd1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    check("R1 done low", 64'(done_o), 64'd0);
    check("R1 read request low", 64'(rd_req_valid_o), 64'd0);
    check("R1 write request low", 64'(wr_req_valid_o), 64'd0);
    check("R1 write valid low", 64'(wr_valid_o), 64'd0);
    check("R1 read ready low", 64'(rd_ready_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    check("R1 idle after reset", 64'({done_o, rd_req_valid_o, wr_req_valid_o, wr_valid_o}), 64'd0);

    // run 1: random data, random stalls on every channel
    for (int n = 0; n < N; n++) src[n] = $urandom;
    do_run(1'b1, 32'h1000_0000, 32'h2000_0000, 1'b0);

    // run 2: directed extremes, no stalls, overflow wrap and throughput
    for (int n = 0; n < N; n++) begin
      case (n % 6)
        0: src[n] = 32'h7FFF_FFFF;
        1: src[n] = 32'h0000_0001;
        2: src[n] = 32'h8000_0000;
        3: src[n] = 32'hFFFF_FFFF;
        4: src[n] = 32'h0000_0000;
        default: src[n] = 32'h8000_0000;
      endcase
    end
    do_run(1'b0, 32'h3000_0100, 32'h4000_0200, 1'b0);
    check("R5 positive overflow wraps", 64'(got[1]), 64'h8000_0000);
    check("R5 negative overflow wraps", 64'(got[3]), 64'h7FFF_FFFF);

    // run 3: random data with stalls and a start pulse while busy
    for (int n = 0; n < N; n++) src[n] = $urandom;
    do_run(1'b1, 32'h5000_0000, 32'h6000_0040, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule